// File: doc/BRIEF.md
# TDM Serial Input Aligner with Bit Delay and Quarter-Bit Sampling

This block receives one serial time-division-multiplexed stream, most significant bit first, and cuts it into 8-bit channel bytes. A single-cycle frame pulse marks the start of each frame. The block runs on a clock at four times the bit rate, so every bit cell lasts four clock cycles. Those cycles are the four quarter positions, numbered 0 to 3. Phase 0 is the first cycle after the clock edge that sees the frame pulse.

A 5-bit control word, `cfg_word[8:4]`, sets two things. The first is how many whole bit cells after the frame pulse the channel 0 boundary falls. The second is which quarter of each bit cell supplies the sampled bit. A narrow mode allows only the half point and the end point of the cell. Both settings, and the mode, are taken only at a frame pulse. Each assembled byte comes out with its channel number and a one-cycle valid strobe. One instance serves one stream, and a design with several streams places one instance for each stream.

Top module: `tdm_in_aligner`

## Requirements
- R1: The all-zero control word selects a delay of 0 and sampling at quarter 2, the 3/4 point. After reset the block outputs `byte_valid`=0 and `samp_err`=0.
- R2: `cfg_word[8:6]` holds the delay D (0 to 7). Bit 7 of channel 0 is the bit cell that starts 4*D+1 clock edges after the edge that sees `frame_pulse`.
- R3: `cfg_word[5:4]` selects the sampling quarter within each bit cell. Code 01 selects quarter 0 (1/4), code 10 quarter 1 (1/2), code 00 quarter 2 (3/4) and code 11 quarter 3 (4/4).
- R4: Bytes are assembled MSB first. `byte_valid` is high for exactly one cycle, just after the edge that samples bit 0. `chan_out` counts 0, 1, 2 and so on, and capture stops after CHANNELS bytes.
- R5: A change of `cfg_word` or `narrow_mode` between frame pulses has no effect on the frame in progress.
- R6: While `narrow_mode` is high at a frame pulse, code 01 is treated as code 10 and code 00 as code 11.
- R7: `samp_err` goes high right after a frame pulse at which a code was forced as in R6. Only reset clears it.
- R8: A frame pulse discards any partly assembled byte and any byte not yet output. The next byte is channel 0 under the new settings.
- R9: Control word 011 10 places channel 0 three bit cells after the pulse, sampled at the 1/2 point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | One-cycle frame start marker |
| ser_in | input | 1 | Serial data, MSB first |
| narrow_mode | input | 1 | Restricts sampling to the 1/2 and 4/4 points |
| cfg_word | input | 5 ([8:4]) | [8:6] bit delay, [5:4] sampling code |
| byte_out | output | 8 | Last assembled channel byte |
| chan_out | output | CW | Channel number of `byte_out` |
| byte_valid | output | 1 | One-cycle strobe for a new byte |
| samp_err | output | 1 | Sticky flag: a sampling code was forced |

## Verification
Let n0 be the clock edge that sees the frame pulse. The byte for channel c is due just after edge n0 + 1 + 4*(D + 8c + 7) + q, where q is the sampling quarter. Bit k of that byte is the serial value present at edge n0 + 1 + 4*(D + 8c + 7 - k) + q. The error flag is due just after edge n0 itself. The bench numbers every clock edge, records the serial value driven before each edge, and computes these edge numbers from the settings in force at the pulse. It samples all outputs one time unit after every rising edge. It expects `byte_valid` high only at the computed edges and low at every other edge.

// File: rtl/tdm_in_pkg.sv
package tdm_in_pkg;

    // Active per-frame settings; ph is the quarter index 0..3 inside a bit cell
    typedef struct packed {
        logic [2:0] dly;
        logic [1:0] ph;
        logic       narrow;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{dly: 3'd0, ph: 2'd2, narrow: 1'b0};

    // Sampling code to quarter index: 01->0, 10->1, 00->2, 11->3
    function automatic logic [1:0] code_to_phase(input logic [1:0] code);
        logic [1:0] r;
        case (code)
            2'b01:   r = 2'd0;
            2'b10:   r = 2'd1;
            2'b00:   r = 2'd2;
            default: r = 2'd3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tdm_in_cfg.sv
module tdm_in_cfg
    import tdm_in_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_pulse,
    input  logic [8:4] cfg_word,
    input  logic       narrow_mode,
    output cfg_t       act,
    output logic       err
);

    typedef struct packed {
        cfg_t act;
        logic err;
    } st_t;

    st_t        st_d, st_q;
    logic [1:0] ph_raw;
    logic       forced;

    always_comb begin
        st_d   = st_q;
        ph_raw = code_to_phase(cfg_word[5:4]);
        // narrow mode only keeps odd quarters (1/2 and 4/4)
        forced = narrow_mode && !ph_raw[0];
        if (frame_pulse) begin
            st_d.act.dly    = cfg_word[8:6];
            st_d.act.ph     = forced ? ph_raw + 2'd1 : ph_raw;
            st_d.act.narrow = narrow_mode;
            if (forced) begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{act: CFG_RESET, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign act = st_q.act;
    assign err = st_q.err;

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_pulse |=> $stable(st_q.act));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);

endmodule

// File: rtl/tdm_in_timer.sv
module tdm_in_timer
    import tdm_in_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_pulse,
    input  cfg_t act,
    output logic samp_stb,
    output logic start_stb
);

    typedef struct packed {
        logic [1:0] ph;     // quarter within current bit cell
        logic [2:0] cells;  // whole bit cells elapsed since the pulse
        logic       arm;    // waiting for the delayed boundary
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        samp_stb  = (st_q.ph == act.ph);
        start_stb = st_q.arm && (st_q.ph == 2'd0) && (st_q.cells == act.dly)
                    && !frame_pulse;

        st_d    = st_q;
        st_d.ph = st_q.ph + 2'd1;
        if (st_q.arm && (st_q.ph == 2'd3)) begin
            st_d.cells = st_q.cells + 3'd1;
        end
        if (start_stb) begin
            st_d.arm = 1'b0;
        end
        if (frame_pulse) begin
            st_d.ph    = 2'd0;
            st_d.cells = 3'd0;
            st_d.arm   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: 2'd0, cells: 3'd0, arm: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (st_q.ph == 2'd0 && st_q.arm));

    // R6
    narrow_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act.narrow && samp_stb) |-> st_q.ph[0]);

endmodule

// File: rtl/tdm_in_asm.sv
module tdm_in_asm #(
    parameter  int CHANNELS = 32,
    localparam int CW       = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_pulse,
    input  logic          samp_stb,
    input  logic          start_stb,
    input  logic          ser_in,
    output logic [7:0]    byte_out,
    output logic [CW-1:0] chan_out,
    output logic          byte_valid
);

    localparam logic [CW-1:0] LAST_CH = CW'(CHANNELS - 1);

    typedef struct packed {
        logic [7:0]    shift;
        logic [2:0]    bitpos;
        logic [CW-1:0] chan;
        logic          run;
        logic [7:0]    byte_o;
        logic [CW-1:0] chan_o;
        logic          valid;
    } st_t;

    st_t           st_d, st_q;
    logic [2:0]    bp;
    logic [CW-1:0] ch;
    logic          running;
    logic [7:0]    nsh;

    always_comb begin
        bp      = start_stb ? 3'd7 : st_q.bitpos;
        ch      = start_stb ? '0 : st_q.chan;
        running = start_stb || st_q.run;
        nsh     = {st_q.shift[6:0], ser_in};

        st_d        = st_q;
        st_d.valid  = 1'b0;
        st_d.bitpos = bp;
        st_d.chan   = ch;
        st_d.run    = running;

        if (running && samp_stb) begin
            st_d.shift = nsh;
            if (bp == 3'd0) begin
                st_d.byte_o = nsh;
                st_d.chan_o = ch;
                st_d.valid  = 1'b1;
                st_d.bitpos = 3'd7;
                st_d.chan   = ch + CW'(1);
                if (ch == LAST_CH) begin
                    st_d.run = 1'b0;
                end
            end else begin
                st_d.bitpos = bp - 3'd1;
            end
        end

        if (frame_pulse) begin
            st_d.run    = 1'b0;
            st_d.bitpos = 3'd7;
            st_d.chan   = '0;
            st_d.valid  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{shift: 8'd0, bitpos: 3'd7, chan: '0, run: 1'b0,
                      byte_o: 8'd0, chan_o: '0, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_out   = st_q.byte_o;
    assign chan_out   = st_q.chan_o;
    assign byte_valid = st_q.valid;

    // R4
    valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R4
    first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> !st_q.valid);

    // R8
    pulse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> !st_q.valid);

endmodule

// File: rtl/tdm_in_aligner.sv
module tdm_in_aligner
    import tdm_in_pkg::*;
#(
    parameter  int CHANNELS = 32,
    localparam int CW       = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_pulse,
    input  logic          ser_in,
    input  logic          narrow_mode,
    input  logic [8:4]    cfg_word,
    output logic [7:0]    byte_out,
    output logic [CW-1:0] chan_out,
    output logic          byte_valid,
    output logic          samp_err
);

    cfg_t act;
    logic samp_stb;
    logic start_stb;

    tdm_in_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .cfg_word    (cfg_word),
        .narrow_mode (narrow_mode),
        .act         (act),
        .err         (samp_err)
    );

    tdm_in_timer u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .act         (act),
        .samp_stb    (samp_stb),
        .start_stb   (start_stb)
    );

    tdm_in_asm #(.CHANNELS(CHANNELS)) u_asm (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .samp_stb    (samp_stb),
        .start_stb   (start_stb),
        .ser_in      (ser_in),
        .byte_out    (byte_out),
        .chan_out    (chan_out),
        .byte_valid  (byte_valid)
    );

endmodule

// File: tb/tdm_in_aligner_tb.sv
module tdm_in_aligner_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CH         = 6;
    localparam int CW         = 3;
    localparam int FULL_BITS  = 8 * CH + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_pulse = 1'b0;
    logic          ser_in = 1'b0;
    logic          narrow_mode = 1'b0;
    logic [8:4]    cfg_word = 5'b00000;
    logic [7:0]    byte_out;
    logic [CW-1:0] chan_out;
    logic          byte_valid;
    logic          samp_err;

    tdm_in_aligner #(.CHANNELS(CH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .ser_in      (ser_in),
        .narrow_mode (narrow_mode),
        .cfg_word    (cfg_word),
        .byte_out    (byte_out),
        .chan_out    (chan_out),
        .byte_valid  (byte_valid),
        .samp_err    (samp_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int edge_n = 0;
    always @(posedge clk) edge_n <= edge_n + 1;

    typedef struct {
        int    dly;
        int    q;
        bit    forced;
        string tag;
    } pls_t;

    typedef struct {
        int    edge_no;
        int    chan;
        int    base;
        int    dly;
        int    q;
        string tag;
    } ev_t;

    bit    stim[int];
    pls_t  pls[int];
    ev_t   evq[$];
    int    checks = 0;
    int    fails  = 0;
    bit    mon_on = 1'b0;
    bit    err_exp = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    logic [15:0] lfsr = 16'hACE1;

    // quarter index from code, per R3, with the R6 narrow-mode forcing
    function automatic int quarter_of(input logic [1:0] code, input bit nar,
                                      output bit forced);
        int q;
        q = (code == 2'b01) ? 0 : (code == 2'b10) ? 1 : (code == 2'b00) ? 2 : 3;
        forced = nar && (q == 0 || q == 2);
        if (forced) q = q + 1;
        return q;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)",
                     req, what, act_v, exp_v, edge_n);
        end
    endtask

    task automatic drive_cycle(input bit p);
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ser_in = lfsr[0];
        frame_pulse = p;
        stim[edge_n + 1] = lfsr[0];
        if (p) begin
            pls_t r;
            r.dly = int'(cfg_word[8:6]);
            r.q   = quarter_of(cfg_word[5:4], narrow_mode, r.forced);
            r.tag = cur_tag;
            pls[edge_n + 1] = r;
        end
    endtask

    // pulse with settings w / nar, then nbits bit cells; optional mid-frame change
    task automatic run_frame(input logic [4:0] w, input bit nar, input int nbits,
                             input string tag, input bit chg);
        cur_tag = tag;
        @(negedge clk);
        cfg_word = w;
        narrow_mode = nar;
        drive_cycle(1'b1);
        for (int i = 0; i < nbits * 4; i++) begin
            drive_cycle(1'b0);
            if (chg && i == 10) begin
                // R5: new word and mode mid-frame must not alter this frame
                cfg_word = ~w;
                narrow_mode = ~nar;
            end
        end
    endtask

    // reference model compared on every clock
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                bit exp_v;
                if (pls.exists(edge_n)) begin
                    pls_t r;
                    r = pls[edge_n];
                    evq.delete();   // R8: pending bytes are dropped
                    if (r.forced) err_exp = 1'b1;
                    for (int c = 0; c < CH; c++) begin
                        ev_t e;
                        e.edge_no = edge_n + 1 + 4 * (r.dly + 8 * c + 7) + r.q;
                        e.chan = c;
                        e.base = edge_n;
                        e.dly  = r.dly;
                        e.q    = r.q;
                        e.tag  = r.tag;
                        evq.push_back(e);
                    end
                end
                exp_v = (evq.size() > 0) && (evq[0].edge_no == edge_n);
                // R2 R4: strobe only at the computed edge
                check(byte_valid === exp_v, "R2/R4", "byte_valid",
                      int'(byte_valid), int'(exp_v));
                if (exp_v) begin
                    ev_t e;
                    logic [7:0] eb;
                    e = evq.pop_front();
                    for (int k = 7; k >= 0; k--) begin
                        int b;
                        b = e.dly + 8 * e.chan + (7 - k);
                        eb[k] = stim[e.base + 1 + 4 * b + e.q];
                    end
                    // R3 R4: MSB-first byte at the chosen quarter
                    check(byte_out === eb, {e.tag, " R3"}, "byte_out",
                          int'(byte_out), int'(eb));
                    check(chan_out === CW'(e.chan), {e.tag, " R4"}, "chan_out",
                          int'(chan_out), e.chan);
                end
                // R7: sticky error flag
                check(samp_err === err_exp, "R7", "samp_err",
                      int'(samp_err), int'(err_exp));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        @(posedge clk);
        #1;
        // R1: reset state
        check(byte_valid === 1'b0, "R1", "byte_valid after reset", int'(byte_valid), 0);
        check(samp_err === 1'b0, "R1", "samp_err after reset", int'(samp_err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (5) drive_cycle(1'b0);

        run_frame(5'b000_00, 1'b0, FULL_BITS, "R1", 1'b0);  // default word
        run_frame(5'b101_01, 1'b0, FULL_BITS, "R2", 1'b0);  // delay 5, 1/4
        run_frame(5'b111_11, 1'b0, FULL_BITS, "R2", 1'b0);  // delay 7, 4/4
        run_frame(5'b001_10, 1'b0, FULL_BITS, "R3", 1'b0);  // delay 1, 1/2
        run_frame(5'b010_01, 1'b0, FULL_BITS, "R3", 1'b0);  // delay 2, 1/4
        run_frame(5'b011_10, 1'b0, FULL_BITS, "R9", 1'b0);  // 3 bits, half point
        run_frame(5'b100_00, 1'b0, FULL_BITS, "R5", 1'b1);  // mid-frame change
        run_frame(5'b010_11, 1'b0, 20, "R8", 1'b0);         // cut short by pulse
        run_frame(5'b000_10, 1'b0, FULL_BITS, "R8", 1'b0);
        run_frame(5'b100_10, 1'b1, FULL_BITS, "R6", 1'b0);  // legal, no error
        run_frame(5'b100_01, 1'b1, FULL_BITS, "R6", 1'b0);  // 01 forced to 1/2
        run_frame(5'b011_00, 1'b1, FULL_BITS, "R6", 1'b0);  // 00 forced to 4/4
        run_frame(5'b001_00, 1'b0, FULL_BITS, "R7", 1'b0);  // flag stays set
        repeat (20) drive_cycle(1'b0);
        finish_run();
    end

endmodule